// File: doc/BRIEF.md
# Text-Mode Character Raster Engine

This block converts a grid of character codes into a monochrome pixel stream for a 480 x 240 visible area. The screen holds 80 columns by 24 rows of text. Each glyph is 5 pixels wide and 8 lines tall and sits inside a cell 6 pixels wide and 10 lines tall. Cell edges therefore fall on neither byte nor power-of-two boundaries. The engine pads the unused cell column and the two unused cell lines with blank pixels.

A display timing generator drives the visible-pixel x/y position and an active strobe. Inside the active area, x advances by one every clock. Each line is announced by a cycle with x = 0, and each frame by a line with y = 0. The block does not divide x and y. It keeps cell counters that wrap at 6 and at 10 and re-synchronise on those start positions. It reads an external character RAM that has a single registered read port, then looks up the glyph in an internal 128-entry table. One pixel comes out per clock, two clocks after the position that produced it.

Top module: `txt_raster_top`

## Requirements
- R1: After a synchronous active-low reset, `pix_o` is 0 and `cram_addr_o` is 0.
- R2: One clock after an active position (x, y) is presented, `cram_addr_o` equals (y / 10) * 80 + (x / 6), using integer division. This address must reach a RAM whose data appear on `cram_data_i` one clock later.
- R3: The pixel for a position presented in cycle n appears on `pix_o` in cycle n + 2.
- R4: Glyph line r (0..7) of code c has 5 bits: bits = c[4:0] XOR {c[6:5], r[2:0]}. Cell column k (0..4) shows bit (4 - k), so the MSB is the leftmost pixel. A 1 lights the pixel.
- R5: Cell column 5 (x mod 6 = 5) is always 0.
- R6: Cell lines 8 and 9 (y mod 10 >= 8) are always 0.
- R7: When the active strobe is low, the pixel two clocks later is 0, whatever the x, y and RAM data are.
- R8: A cycle with x = 0 restarts the column counters. When y = 0 as well, the row counters restart too, so a new frame renders correctly after any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_x_i | input | 9 | Visible pixel column, 0..479 |
| pos_y_i | input | 8 | Visible line, 0..239 |
| active_i | input | 1 | High while the position lies in the visible area |
| cram_addr_o | output | 11 | Character RAM read address, row*80+column |
| cram_data_i | input | 7 | Character code returned by the RAM one clock after the address |
| pix_o | output | 1 | Rendered pixel |

## Verification
The main coincidence is at the right edge of the screen. On the cycle after x = 479 (cell column 5), the column counter wraps at the same moment the x = 0 restart arrives. On the last line of a cell row, the line counter wraps in the same cycle the row counter advances. The bench renders a whole frame, followed by the first rows of a second frame. It compares every pixel and every RAM address with values derived from integer division of x and y. A counter that mishandles either coincidence shifts whole rows or columns, and that shift shows up as mismatches.

// File: rtl/txt_raster_pkg.sv
// Package: geometry constants shared by the text raster engine.
// Assumes a fixed 80x24 text grid with 6x10 cells and 5x8 glyphs.
package txt_raster_pkg;
    localparam int TXT_COLS   = 80;
    localparam int TXT_ROWS   = 24;
    localparam int CELL_W     = 6;
    localparam int CELL_H     = 10;
    localparam int GLYPH_W    = 5;
    localparam int GLYPH_H    = 8;
    localparam int CODE_W     = 7;
    localparam int VIS_W      = TXT_COLS * CELL_W;
    localparam int VIS_H      = TXT_ROWS * CELL_H;
    localparam int X_W        = $clog2(VIS_W);
    localparam int Y_W        = $clog2(VIS_H);
    localparam int SUBX_W     = $clog2(CELL_W);
    localparam int SUBY_W     = $clog2(CELL_H);
    localparam int COL_W      = $clog2(TXT_COLS);
    localparam int ROW_W      = $clog2(TXT_ROWS);
    localparam int ADDR_W     = $clog2(TXT_COLS * TXT_ROWS);
    localparam int GLY_LINE_W = $clog2(GLYPH_H);
    localparam int NUM_CODES  = 1 << CODE_W;
endpackage

// File: rtl/txt_cell_tracker.sv
// Module: txt_cell_tracker
// Follows the raster position with cell counters instead of dividers.
// Inside a cell row it keeps the column within the cell (wraps at CELL_W)
// and the cell column; across lines it keeps the line within the cell
// (wraps at CELL_H) and the cell row. It assumes x steps by one each
// active clock, that every line starts with x = 0, and that y steps by
// one per line, starting from 0 on each frame.
module txt_cell_tracker
    import txt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [X_W-1:0]    x_i,
    input  logic [Y_W-1:0]    y_i,
    output logic              act_o,
    output logic [SUBX_W-1:0] subx_o,
    output logic [SUBY_W-1:0] suby_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam logic [SUBX_W-1:0] SUBX_LAST = SUBX_W'(CELL_W - 1);
    localparam logic [SUBY_W-1:0] SUBY_LAST = SUBY_W'(CELL_H - 1);

    // Horizontal counters: restart at line start, else step with wrap at the cell width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            subx_o <= '0;
            col_o  <= '0;
        end else if (act_i) begin
            if (x_i == '0) begin
                subx_o <= '0;
                col_o  <= '0;
            end else if (subx_o == SUBX_LAST) begin
                subx_o <= '0;
                col_o  <= col_o + 1'b1;
            end else begin
                subx_o <= subx_o + 1'b1;
            end
        end
    end

    // Vertical counters: advance once per line start, restart on the first line of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            suby_o <= '0;
            row_o  <= '0;
        end else if (act_i && x_i == '0) begin
            if (y_i == '0) begin
                suby_o <= '0;
                row_o  <= '0;
            end else if (suby_o == SUBY_LAST) begin
                suby_o <= '0;
                row_o  <= row_o + 1'b1;
            end else begin
                suby_o <= suby_o + 1'b1;
            end
        end
    end

    // Active flag delayed to align with the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) act_o <= 1'b0;
        else        act_o <= act_i;
    end

    // R8
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && x_i == '0) |=> (subx_o == '0 && col_o == '0));
    // R8
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && x_i == '0 && y_i == '0) |=> (suby_o == '0 && row_o == '0));
    // R2
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && x_i != '0 && subx_o == SUBX_LAST) |=>
            (subx_o == '0 && col_o == $past(col_o) + 1'b1));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> ($stable(subx_o) && $stable(col_o) && $stable(suby_o) && $stable(row_o)));
endmodule

// File: rtl/txt_glyph_rom.sv
// Module: txt_glyph_rom
// Constant glyph table, NUM_CODES codes by GLYPH_H lines of GLYPH_W bits.
// The contents are computed at elaboration: line r of code c is
// c[4:0] XOR {c[6:5], r[2:0]}. The lookup is purely combinational.
module txt_glyph_rom
    import txt_raster_pkg::*;
(
    input  logic [CODE_W-1:0]     code_i,
    input  logic [GLY_LINE_W-1:0] line_i,
    output logic [GLYPH_W-1:0]    bits_o
);
    localparam int DEPTH = NUM_CODES * GLYPH_H;

    logic [GLYPH_W-1:0] table_q [DEPTH];

    // Fill every table entry with its computed line pattern.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        for (genvar r = 0; r < GLYPH_H; r++) begin : g_line
            localparam logic [CODE_W-1:0]     CV = CODE_W'(c);
            localparam logic [GLY_LINE_W-1:0] RV = GLY_LINE_W'(r);
            assign table_q[c*GLYPH_H + r] = CV[4:0] ^ {CV[6:5], RV};
        end
    end

    // Read the entry selected by code and line.
    always_comb bits_o = table_q[{code_i, line_i}];
endmodule

// File: rtl/txt_raster_top.sv
// Module: txt_raster_top
// Two-stage text renderer. Stage 1 holds the cell counters and drives the
// character RAM address. Stage 2 holds the in-cell offsets while the RAM
// returns the code; the glyph lookup and padding mask then form the pixel.
// Assumes a character RAM with exactly one clock of read latency.
module txt_raster_top
    import txt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8:0]        pos_x_i,
    input  logic [7:0]        pos_y_i,
    input  logic              active_i,
    output logic [10:0]       cram_addr_o,
    input  logic [6:0]        cram_data_i,
    output logic              pix_o
);
    logic              act1, act2;
    logic [SUBX_W-1:0] subx1, subx2;
    logic [SUBY_W-1:0] suby1, suby2;
    logic [COL_W-1:0]  col1;
    logic [ROW_W-1:0]  row1;
    logic [GLYPH_W-1:0] gbits;
    logic              in_glyph;
    logic              gbit;

    txt_cell_tracker u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (active_i),
        .x_i    (pos_x_i),
        .y_i    (pos_y_i),
        .act_o  (act1),
        .subx_o (subx1),
        .suby_o (suby1),
        .col_o  (col1),
        .row_o  (row1)
    );

    // Character RAM address from the stage 1 cell coordinates.
    always_comb cram_addr_o = ADDR_W'(row1) * ADDR_W'(TXT_COLS) + ADDR_W'(col1);

    // Stage 2: carry in-cell offsets while the RAM read is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act2  <= 1'b0;
            subx2 <= '0;
            suby2 <= '0;
        end else begin
            act2  <= act1;
            subx2 <= subx1;
            suby2 <= suby1;
        end
    end

    txt_glyph_rom u_rom (
        .code_i (cram_data_i),
        .line_i (suby2[GLY_LINE_W-1:0]),
        .bits_o (gbits)
    );

    // Mask padding and pick the glyph bit, leftmost pixel from the MSB.
    always_comb begin
        in_glyph = (subx2 < SUBX_W'(GLYPH_W)) && (suby2 < SUBY_W'(GLYPH_H));
        gbit     = in_glyph ? gbits[3'(GLYPH_W - 1) - subx2] : 1'b0;
        pix_o    = act2 && gbit;
    end

    // R7
    idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(act1) |-> !pix_o);
    // R5
    pad_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (subx2 == SUBX_W'(CELL_W - 1)) |-> !pix_o);
    // R6
    pad_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suby2 >= SUBY_W'(GLYPH_H)) |-> !pix_o);
    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act1 |-> (cram_addr_o < 11'(TXT_COLS * TXT_ROWS)));
endmodule

// File: tb/txt_raster_top_tb.sv
// Bench: renders a full frame plus the start of a second frame and compares
// every pixel and RAM address with values computed by integer division.
module txt_raster_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  pos_x = '0;
    logic [7:0]  pos_y = '0;
    logic        active = 1'b0;
    logic [10:0] cram_addr;
    logic [6:0]  cram_data;
    logic        pix;

    int n_cmp = 0;
    int n_bad = 0;
    int frame2 = 0;

    int hx1 = 0, hy1 = 0, hx2 = 0, hy2 = 0;
    bit ha1 = 0, ha2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txt_raster_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_x_i     (pos_x),
        .pos_y_i     (pos_y),
        .active_i    (active),
        .cram_addr_o (cram_addr),
        .cram_data_i (cram_data),
        .pix_o       (pix)
    );

    function automatic int ram_code(input int a);
        return (a * 37 + 11) % 128;
    endfunction

    // Character RAM model with one registered read cycle.
    always_ff @(posedge clk) cram_data <= 7'(ram_code(int'(cram_addr)));

    function automatic bit exp_pix(input int x, input int y, input bit a);
        int c, r, k, bits;
        if (!a) return 1'b0;
        k = x % 6;
        r = y % 10;
        if (k == 5 || r >= 8) return 1'b0;
        c = ram_code((y / 10) * 80 + x / 6);
        bits = (c & 31) ^ ((((c >> 5) & 3) << 3) | r);
        return 1'((bits >> (4 - k)) & 1);
    endfunction

    task automatic step(input int x, input int y, input bit a);
        bit e;
        int ea;
        @(negedge clk);
        // R3 R4 R5 R6 R7 R8: pixel from two cycles back
        e = exp_pix(hx2, hy2, ha2);
        n_cmp++;
        if (pix !== e) begin
            n_bad++;
            if (!ha2)                 $display("FAIL R7 x=%0d y=%0d pix=%b exp=%b", hx2, hy2, pix, e);
            else if (hx2 % 6 == 5)    $display("FAIL R5 x=%0d y=%0d pix=%b exp=%b", hx2, hy2, pix, e);
            else if (hy2 % 10 >= 8)   $display("FAIL R6 x=%0d y=%0d pix=%b exp=%b", hx2, hy2, pix, e);
            else if (frame2 != 0)     $display("FAIL R8 x=%0d y=%0d pix=%b exp=%b", hx2, hy2, pix, e);
            else                      $display("FAIL R4/R3 x=%0d y=%0d pix=%b exp=%b", hx2, hy2, pix, e);
        end
        // R2: address from one cycle back
        if (ha1) begin
            ea = (hy1 / 10) * 80 + hx1 / 6;
            n_cmp++;
            if (int'(cram_addr) != ea) begin
                n_bad++;
                $display("FAIL R2 x=%0d y=%0d addr=%0d exp=%0d", hx1, hy1, cram_addr, ea);
            end
        end
        hx2 = hx1; hy2 = hy1; ha2 = ha1;
        hx1 = x;   hy1 = y;   ha1 = a;
        pos_x = 9'(x); pos_y = 8'(y); active = a;
    endtask

    task automatic render_lines(input int nlines);
        for (int y = 0; y < nlines; y++) begin
            for (int x = 0; x < 480; x++) step(x, y, 1'b1);
            // horizontal blanking with stray positions that must stay dark
            for (int b = 0; b < 20; b++) step(b * 7, y, 1'b0);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (pix !== 1'b0) begin n_bad++; $display("FAIL R1 pix=%b exp=0", pix); end
        n_cmp++;
        if (cram_addr !== 11'd0) begin n_bad++; $display("FAIL R1 addr=%0d exp=0", cram_addr); end
        rst_n = 1'b1;
        repeat (4) step(0, 0, 1'b0);
        render_lines(240);
        for (int v = 0; v < 3; v++) for (int b = 0; b < 500; b++) step(b % 480, 100, 1'b0);
        frame2 = 1;
        render_lines(25);
        repeat (3) step(0, 0, 1'b0);
        summary();
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule